// File: doc/BRIEF.md
# Scheduled Battery Health Monitor

This block decides when a backup battery is checked and keeps a latched warning when a check finds the battery weak. An external comparator judges the battery voltage and presents one digital flag, high when the battery is above its threshold. This block tells the comparator when to sample by raising a one-cycle strobe. On the clock edge that ends the following cycle, it reads the flag.

A check runs each time the main supply becomes good, and also right after reset if the supply is already good. After that, further checks run at a long fixed interval for as long as the supply stays good. The interval is counted as a number of slow ticks, and each tick is a fixed number of clock cycles. No check runs while the supply is bad. The interval count is cleared whenever the supply is bad, so it starts again after each power-up check.

The warning output is active low. It is set by a failing check and cleared only by a later passing check or by the module reset. It keeps its value while the supply is lost.

Top module: `batt_watch`

## Requirements
- R1: While `rst_n` is low and after its release, before any check completes, `sample_stb` is 0 and `batt_low_n` is 1.
- R2: On the first rising clock edge at which `supply_ok` is seen high after being low (or after reset), a check starts. `sample_stb` is high for exactly the one cycle that follows that edge.
- R3: A check captures `batt_above` at the clock edge that ends the cycle after the strobe cycle. From that edge on, `batt_low_n` equals the captured value (0 means the battery is weak).
- R4: While `supply_ok` stays high, each strobe rises exactly TICK_DIV*INTERVAL_TICKS+2 clock cycles after the previous one.
- R5: Changes of `batt_above` outside the capture edge of a check have no effect on `batt_low_n`.
- R6: Once `batt_low_n` is 0, it returns to 1 only when a later check captures `batt_above`=1 (or on reset).
- R7: No strobe is issued in the cycle after any edge at which `supply_ok` is low.
- R8: `batt_low_n` keeps its value while `supply_ok` is low.
- R9: The interval count restarts at each power-up check. The first scheduled check after a power-up comes TICK_DIV*INTERVAL_TICKS+2 cycles after the power-up strobe, whatever time elapsed before the supply was lost.
- R10: If `supply_ok` is low at the capture edge, the check is abandoned and `batt_low_n` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | High while the main supply is nominal |
| batt_above | input | 1 | Comparator flag, high when the battery is above threshold |
| sample_stb | output | 1 | One-cycle request for the comparator to sample |
| batt_low_n | output | 1 | Latched battery warning, low when weak |

## Verification
Four things are checked by properties on every cycle:
- the strobe is a single-cycle pulse that follows each supply rise;
- no strobe is issued while the supply is bad;
- the warning output changes only two edges after a strobe;
- an abandoned capture leaves the warning untouched.

The exact spacing of scheduled checks, the restart of that spacing after a power-up, and the value kept across supply loss can only be shown by the bench. It does this by timing strobes against the requirement formula and by running supply cycles with chosen battery flags.

// File: rtl/batt_watch.sv
module batt_watch #(
  parameter int unsigned TICK_DIV       = 50_000_000,
  parameter int unsigned INTERVAL_TICKS = 86_400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic batt_above,
  output logic sample_stb,
  output logic batt_low_n
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int TW = (INTERVAL_TICKS > 1) ? $clog2(INTERVAL_TICKS) : 1;

  typedef enum logic [1:0] {IDLE, STROBE, SETTLE} chk_t;

  chk_t          st;
  logic          sup_q;
  logic          low_q;
  logic [PW-1:0] pre;
  logic [TW-1:0] tcnt;

  wire run      = (st == IDLE) && supply_ok;
  wire tick     = pre == PW'(TICK_DIV - 1);
  wire due      = run && tick && (tcnt == TW'(INTERVAL_TICKS - 1));
  wire pwr_rise = supply_ok && !sup_q;
  wire start    = run && (pwr_rise || due);

  assign sample_stb = (st == STROBE);
  assign batt_low_n = ~low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sup_q <= 1'b0;
    else        sup_q <= supply_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre  <= '0;
      tcnt <= '0;
    end else if (!run || start) begin
      pre  <= '0;
      tcnt <= '0;
    end else if (tick) begin
      pre  <= '0;
      tcnt <= tcnt + 1'b1;
    end else begin
      pre  <= pre + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= IDLE;
    else if (!supply_ok) st <= IDLE;
    else begin
      case (st)
        IDLE:    if (start) st <= STROBE;
        STROBE:  st <= SETTLE;
        SETTLE:  st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= 1'b0;
    else if (st == SETTLE && supply_ok) low_q <= ~batt_above;
  end

  // R2
  powerup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(supply_ok) |=> sample_stb);

  // R2
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  // R7
  stb_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !sample_stb);

  // R5
  low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(batt_low_n) |-> $past(sample_stb, 2));

  // R10
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb ##1 !supply_ok |=> $stable(batt_low_n));
endmodule

// File: tb/batt_watch_bench.sv
module batt_watch_bench;
  localparam int TD = 3;
  localparam int IT = 4;
  localparam int PERIOD = TD * IT + 2;
  localparam int NV = 6;
  localparam logic [1:0] VEC [NV] = '{2'b11, 2'b00, 2'b00, 2'b11, 2'b11, 2'b00};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic batt_above = 1'b1;
  logic sample_stb, batt_low_n;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  batt_watch #(.TICK_DIV(TD), .INTERVAL_TICKS(IT)) u_batt_watch (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .batt_above(batt_above),
    .sample_stb(sample_stb), .batt_low_n(batt_low_n));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic powerup(logic b, logic exp);
    batt_above = b;
    supply_ok = 1'b1;
    step(1);
    chk("R2 strobe after supply rise", int'(sample_stb), 1);
    step(1);
    chk("R2 strobe one cycle", int'(sample_stb), 0);
    step(1);
    chk("R3 captured result", int'(batt_low_n), int'(exp));
  endtask

  task automatic powerdown();
    supply_ok = 1'b0;
    step(2);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    int strobes;
    step(3);
    chk("R1 reset strobe", int'(sample_stb), 0);
    chk("R1 reset output", int'(batt_low_n), 1);
    rst_n = 1'b1;
    step(2);
    chk("R1 after release", int'(batt_low_n), 1);

    for (int i = 0; i < NV; i++) begin
      powerup(VEC[i][1], VEC[i][0]);
      batt_above = ~VEC[i][1];
      step(4);
      chk("R5 flag change ignored", int'(batt_low_n), int'(VEC[i][0]));
      powerdown();
      step(3);
      chk("R8 kept during supply loss", int'(batt_low_n), int'(VEC[i][0]));
    end

    // R7: long outage, no strobes
    strobes = 0;
    batt_above = 1'b1;
    for (int k = 0; k < 4 * PERIOD; k++) begin
      @(negedge clk);
      if (sample_stb) strobes++;
    end
    chk("R7 no strobe on battery", strobes, 0);
    chk("R8 latch across outage", int'(batt_low_n), 0);

    // R6: low stays until a check passes; R9 interval restarts at power-up
    powerup(1'b0, 1'b0);
    batt_above = 1'b1;
    n = 2;
    do begin @(negedge clk); n++; end while (!sample_stb && n < 10 * PERIOD);
    chk("R6 held until check", int'(batt_low_n), 0);
    chk("R9 first scheduled check", n, PERIOD);
    step(2);
    chk("R6 cleared by passing check", int'(batt_low_n), 1);

    // R4: next scheduled check fails
    n = 2;
    do begin @(negedge clk); n++; end while (!sample_stb && n < 10 * PERIOD);
    chk("R4 periodic spacing", n, PERIOD);
    batt_above = 1'b0;
    step(2);
    chk("R3 periodic failing check", int'(batt_low_n), 0);
    n = 2;
    do begin @(negedge clk); n++; end while (!sample_stb && n < 10 * PERIOD);
    chk("R4 periodic spacing again", n, PERIOD);
    batt_above = 1'b1;
    step(2);
    chk("R6 periodic pass clears", int'(batt_low_n), 1);

    // R10: supply lost after strobe abandons the check
    powerdown();
    batt_above = 1'b0;
    supply_ok = 1'b1;
    step(1);
    chk("R2 strobe before abort", int'(sample_stb), 1);
    supply_ok = 1'b0;
    step(3);
    chk("R10 abandoned check", int'(batt_low_n), 1);

    // R1: reset clears a latched warning
    powerup(1'b0, 1'b0);
    rst_n = 1'b0;
    step(1);
    chk("R1 reset clears warning", int'(batt_low_n), 1);
    finish_run();
  end
endmodule